// File: doc/BRIEF.md
# Multi-Channel Match-Event PWM Timer

This block generates several pulse-width modulated outputs from a single shared counter. A slow counting tick comes from the system clock through two cascaded divide stages. One limit value sets the period for every channel. Each channel has its own compare value. As the counter leaves certain values it raises match events, and these events set or clear the channel outputs. The counter either wraps from the limit back to zero, which gives edge-aligned pulses, or turns at the limit and counts back down to zero, which gives pulses centred in the period.

Software configures the block through a narrow write port. The port holds the limit, the compare values, the two divide factors, the per-channel inversion and enable masks, and a control word for halt, clear and counting mode. Compare and limit writes land in shadow copies. These copies reach the match logic only while the counter is halted, so a running waveform never sees a half-changed setting. The live counter value is always visible on an output port.

Top module: `mpwm_timer`

## Requirements
- R1: A counting tick occurs once every (A+1)*(B+1) clock cycles. A is bits [7:0] and B is bits [15:8] of the divider word at address 2. The counter moves only on a tick. The first step after a release lands (A+1)*(B+1) cycles after the edge that samples the release write.
- R2: In edge mode (control bit 2 = 0), the counter runs 0, 1, … L and then returns to 0. L is the limit at address 1, so one period is L+1 ticks.
- R3: In center mode (control bit 2 = 1), the counter runs up from 0 to L and then back down to 0. One period is 2L ticks.
- R4: On a tick, leaving count 0 raises the zero event and leaving count C[n] raises channel n's event. C[n] is the compare at address 8+n. In edge mode, a compare equal to L raises no channel event. For a channel that is not inverted, on an up step the zero event sets the output and the channel event clears it. The output register updates on the same edge as the counter. As a result, C[n]=0 gives a constantly low output and C[n]=L gives a constantly high output.
- R5: Setting bit n of the inversion mask (address 3) swaps the roles for channel n: the zero event clears and the channel event sets.
- R6: In center mode, on a step that goes down (the step leaving L, and every step until 0 is reached), each channel's set and clear actions are swapped again.
- R7: When a channel's set and clear fall on the same tick, the output goes low.
- R8: Control word (address 0): bit 0 halts the block, freezing the counter, the divide stages and the outputs. Bit 1 clears the counter to zero, resets the direction to up and restarts the divide stages.
- R9: Compare and limit writes reach the match logic only while the block is halted. A write made while running leaves the running waveform unchanged.
- R10: A limit write is dropped while any bit of the channel enable mask (address 4) is set.
- R11: A channel whose enable bit is 0 drives a low output.
- R12: After reset the counter reads 0, all outputs are low and the block is halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | CW | Register write data |
| count_out | output | CW | Live counter value |
| pwm_out | output | NCH | PWM outputs, one per channel |

## Verification
The assertions assume the register port is used in the intended order. Software first halts and clears the counter, then writes the limit, compares and divide factors, and only then releases it. They also assume every compare stays at or below the limit and that the limit is at least one. The stimulus follows this order in every case, directed or random. It draws compares from 0 to the limit inclusive, so both extreme duty cases appear often. Writes made while running touch only compares or a locked limit, and the bench predicts that these have no effect.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;
    // register word addresses
    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_LIMIT = 1;
    localparam int unsigned A_DIV   = 2;
    localparam int unsigned A_INV   = 3;
    localparam int unsigned A_EN    = 4;
    localparam int unsigned A_CMP0  = 8;
    // control word bits
    localparam int unsigned CB_HALT   = 0;
    localparam int unsigned CB_CLEAR  = 1;
    localparam int unsigned CB_CENTER = 2;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/mpwm_regs.sv
`timescale 1ns/1ps
module mpwm_regs
    import mpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 8,
    parameter int AW  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic                     halt,
    output logic                     clear,
    output logic                     center,
    output logic [DW-1:0]            div_a,
    output logic [DW-1:0]            div_b,
    output logic [NCH-1:0]           inv,
    output logic [NCH-1:0]           chan_en,
    output logic [CW-1:0]            limit,
    output logic [NCH-1:0][CW-1:0]   cmp
);
    typedef struct packed {
        logic                   halt;
        logic                   clear;
        logic                   center;
        logic [DW-1:0]          div_a;
        logic [DW-1:0]          div_b;
        logic [NCH-1:0]         inv;
        logic [NCH-1:0]         en;
        logic [CW-1:0]          lim_sh;
        logic [CW-1:0]          lim;
        logic [NCH-1:0][CW-1:0] cmp_sh;
        logic [NCH-1:0][CW-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.clear = 1'b0;
        if (r_q.halt) begin
            r_d.lim = r_q.lim_sh;
            r_d.cmp = r_q.cmp_sh;
        end
        if (wr_en) begin
            if (wr_addr == AW'(A_CTRL)) begin
                r_d.halt   = wr_data[CB_HALT];
                r_d.clear  = wr_data[CB_CLEAR];
                r_d.center = wr_data[CB_CENTER];
            end
            if (wr_addr == AW'(A_LIMIT) && r_q.en == '0) begin
                r_d.lim_sh = wr_data;
            end
            if (wr_addr == AW'(A_DIV)) begin
                r_d.div_a = wr_data[DW-1:0];
                r_d.div_b = wr_data[2*DW-1:DW];
            end
            if (wr_addr == AW'(A_INV)) begin
                r_d.inv = wr_data[NCH-1:0];
            end
            if (wr_addr == AW'(A_EN)) begin
                r_d.en = wr_data[NCH-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(A_CMP0 + i)) begin
                    r_d.cmp_sh[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.halt <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign halt    = r_q.halt;
    assign clear   = r_q.clear;
    assign center  = r_q.center;
    assign div_a   = r_q.div_a;
    assign div_b   = r_q.div_b;
    assign inv     = r_q.inv;
    assign chan_en = r_q.en;
    assign limit   = r_q.lim;
    assign cmp     = r_q.cmp;

    AST_LIMIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en != '0) |=> $stable(r_q.lim_sh)); // R10
    AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.halt |=> ($stable(r_q.lim) && $stable(r_q.cmp))); // R9
endmodule

// File: rtl/mpwm_clkdiv.sv
`timescale 1ns/1ps
module mpwm_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic [DW-1:0] div_a,
    input  logic [DW-1:0] div_b,
    output logic          tick
);
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d  = d_q;
        tick = run && !clear && (d_q.a == div_a) && (d_q.b == div_b);
        if (!run || clear) begin
            d_d = '0;
        end else if (d_q.a == div_a) begin
            d_d.a = '0;
            d_d.b = (d_q.b == div_b) ? '0 : d_q.b + DW'(1);
        end else begin
            d_d.a = d_q.a + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && d_q.a != div_a) |=> $stable(d_q.b)); // R1
endmodule

// File: rtl/mpwm_counter.sv
`timescale 1ns/1ps
module mpwm_counter
    import mpwm_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          center,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          going_down
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        dir_e          dir;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        going_down = center && (c_q.cnt != '0) &&
                     ((c_q.dir == DIR_DOWN) || (c_q.cnt >= limit));
        if (clear) begin
            c_d.cnt = '0;
            c_d.dir = DIR_UP;
        end else if (tick) begin
            if (limit == '0) begin
                c_d.cnt = '0;
                c_d.dir = DIR_UP;
            end else if (going_down) begin
                c_d.cnt = c_q.cnt - CW'(1);
                c_d.dir = DIR_DOWN;
            end else if (!center && c_q.cnt >= limit) begin
                c_d.cnt = '0;
                c_d.dir = DIR_UP;
            end else begin
                c_d.cnt = c_q.cnt + CW'(1);
                c_d.dir = DIR_UP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cnt: '0, dir: DIR_UP};
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(c_q.cnt)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (c_q.cnt == '0 && c_q.dir == DIR_UP)); // R8
    AST_CENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && center && limit != '0) |=>
        (c_q.cnt == $past(c_q.cnt) + CW'(1) || c_q.cnt == $past(c_q.cnt) - CW'(1))); // R3
    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !center && c_q.cnt >= limit) |=> (c_q.cnt == '0)); // R2
endmodule

// File: rtl/mpwm_chan.sv
`timescale 1ns/1ps
module mpwm_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] limit,
    input  logic          center,
    input  logic          going_down,
    input  logic          inv,
    input  logic          en,
    output logic          pwm
);
    typedef struct packed {
        logic lvl;
    } ch_t;

    ch_t  o_d, o_q;
    logic hit_zero, hit_cmp, swap, do_set, do_clr;

    always_comb begin
        hit_zero = tick && (count == '0);
        hit_cmp  = tick && (count == cmp) && (center || cmp != limit);
        swap     = inv ^ going_down;
        do_set   = swap ? hit_cmp  : hit_zero;
        do_clr   = swap ? hit_zero : hit_cmp;
        o_d      = o_q;
        if (!en)         o_d.lvl = 1'b0;
        else if (do_clr) o_d.lvl = 1'b0;
        else if (do_set) o_d.lvl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pwm = o_q.lvl;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_set && do_clr) |=> !pwm); // R7
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm); // R11
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(pwm)); // R4
endmodule

// File: rtl/mpwm_timer.sv
`timescale 1ns/1ps
module mpwm_timer #(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 8,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [CW-1:0]  count_out,
    output logic [NCH-1:0] pwm_out
);
    logic                   halt_w, clear_w, center_w, tick_w, down_w;
    logic [DW-1:0]          div_a_w, div_b_w;
    logic [NCH-1:0]         inv_w, en_w;
    logic [CW-1:0]          limit_w, count_w;
    logic [NCH-1:0][CW-1:0] cmp_w;

    mpwm_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .halt(halt_w), .clear(clear_w), .center(center_w),
        .div_a(div_a_w), .div_b(div_b_w), .inv(inv_w), .chan_en(en_w),
        .limit(limit_w), .cmp(cmp_w)
    );

    mpwm_clkdiv #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!halt_w), .clear(clear_w),
        .div_a(div_a_w), .div_b(div_b_w), .tick(tick_w)
    );

    mpwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .clear(clear_w),
        .center(center_w), .limit(limit_w), .count(count_w),
        .going_down(down_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mpwm_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_w), .count(count_w),
            .cmp(cmp_w[g]), .limit(limit_w), .center(center_w),
            .going_down(down_w), .inv(inv_w[g]), .en(en_w[g]),
            .pwm(pwm_out[g])
        );
    end

    assign count_out = count_w;
endmodule

// File: tb/sim_mpwm_timer.sv
`timescale 1ns/1ps
module sim_mpwm_timer;
    localparam int NCH = 4;
    localparam int CW  = 32;
    localparam int DW  = 8;
    localparam int AW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] pwm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int             cfg_top, cfg_a, cfg_b, cfg_ncyc;
    int             cfg_cmp[NCH];
    bit [NCH-1:0]   cfg_inv, cfg_en;
    bit             cfg_center, cfg_lock, cfg_mid;

    mpwm_timer #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_out(cnt), .pwm_out(pwm)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [CW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int exp_cnt(input int top, input bit center, input int k);
        int kk;
        if (!center) return k % (top + 1);
        kk = k % (2 * top);
        return (kk <= top) ? kk : 2 * top - kk;
    endfunction

    function automatic bit exp_lvl(input int top, input int c, input bit center,
                                   input bit inv, input int k);
        int kk, v;
        bit p;
        if (!center) begin
            v = k % (top + 1);
            p = (c == top) || (v >= 1 && v <= c);
        end else begin
            kk = k % (2 * top);
            v = (kk <= top) ? kk : 2 * top - kk;
            p = (kk >= 1 && kk <= top) ? (v <= c) : (v < c);
        end
        if (inv) return (c == 0) ? 1'b0 : !p;
        return p;
    endfunction

    task automatic run_case();
        int per, k, ec;
        bit el;
        string rq;
        wr(0, 32'd3);                        // halt and clear
        if (cfg_lock) begin
            wr(1, CW'(cfg_top + 9));         // dropped: channels still enabled (R10)
        end else begin
            wr(4, '0);
            wr(1, CW'(cfg_top));
        end
        for (int ch = 0; ch < NCH; ch++) wr(8 + ch, CW'(cfg_cmp[ch]));
        wr(2, CW'((cfg_b << 8) | cfg_a));
        wr(3, CW'(cfg_inv));
        wr(4, CW'(cfg_en));
        wr(0, CW'((int'(cfg_center) << 2) | 1));
        repeat (2) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(0); wr_data = CW'(int'(cfg_center) << 2);
        @(posedge clk);
        per = (cfg_a + 1) * (cfg_b + 1);
        for (int m = 0; m <= cfg_ncyc; m++) begin
            @(negedge clk);
            if (m == 0) wr_en = 1'b0;
            if (cfg_mid && m == cfg_ncyc / 2) begin
                wr_en = 1'b1; wr_addr = AW'(8);
                wr_data = (cfg_cmp[0] == 0) ? CW'(cfg_top) : '0;
            end
            if (cfg_mid && m == cfg_ncyc / 2 + 1) wr_en = 1'b0;
            k = m / per;
            if (k >= 1) begin
                ec = exp_cnt(cfg_top, cfg_center, k);
                chk(cnt == CW'(ec), cfg_lock ? "R10" : (cfg_center ? "R1,R3" : "R1,R2"),
                    longint'(cnt), longint'(ec));
                for (int ch = 0; ch < NCH; ch++) begin
                    el = cfg_en[ch] ? exp_lvl(cfg_top, cfg_cmp[ch], cfg_center, cfg_inv[ch], k) : 1'b0;
                    if (!cfg_en[ch])                        rq = "R11";
                    else if (cfg_mid && ch == 0 && m > cfg_ncyc / 2) rq = "R9";
                    else if (cfg_cmp[ch] == 0)              rq = "R7";
                    else if (cfg_inv[ch])                   rq = "R5";
                    else if (cfg_center)                    rq = "R6";
                    else                                    rq = "R4";
                    chk(pwm[ch] == el, rq, longint'(pwm[ch]), longint'(el));
                end
            end
        end
    endtask

    task automatic halt_test();
        logic [CW-1:0]  held_c;
        logic [NCH-1:0] held_p;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(0); wr_data = CW'((int'(cfg_center) << 2) | 1);
        @(negedge clk);
        wr_en = 1'b0;
        held_c = cnt; held_p = pwm;
        repeat (10) @(negedge clk);
        chk(cnt == held_c, "R8", longint'(cnt), longint'(held_c));
        chk(pwm == held_p, "R8", longint'(pwm), longint'(held_p));
        wr(0, 32'd3);
        @(negedge clk);
        chk(cnt == '0, "R8", longint'(cnt), 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt == '0, "R12", longint'(cnt), 0);
        chk(pwm == '0, "R12", longint'(pwm), 0);

        // directed: edge mode, extremes of compare
        cfg_top = 7; cfg_cmp = '{0, 7, 3, 5}; cfg_inv = '0; cfg_en = '1;
        cfg_center = 0; cfg_a = 0; cfg_b = 0; cfg_lock = 0; cfg_mid = 0; cfg_ncyc = 40;
        run_case();
        // directed: center mode
        cfg_top = 6; cfg_cmp = '{0, 6, 2, 4}; cfg_center = 1; cfg_ncyc = 50;
        run_case();
        // directed: inverted, both modes
        cfg_inv = '1; run_case();
        cfg_center = 0; cfg_top = 5; cfg_cmp = '{0, 5, 1, 3}; run_case();
        // directed: divider and disabled channels, compare written while running
        cfg_inv = 4'b0010; cfg_en = 4'b0101; cfg_a = 1; cfg_b = 2; cfg_mid = 1; cfg_ncyc = 160;
        run_case();
        // directed: limit write dropped while channels enabled
        cfg_lock = 1; cfg_mid = 0; cfg_a = 0; cfg_b = 1; cfg_ncyc = 40;
        run_case();
        halt_test();

        for (int n = 0; n < 30; n++) begin
            cfg_top = 1 + int'($urandom % 12);
            for (int ch = 0; ch < NCH; ch++) cfg_cmp[ch] = int'($urandom % (cfg_top + 1));
            cfg_inv = NCH'($urandom);
            cfg_en = NCH'($urandom) | NCH'(1);
            cfg_center = bit'($urandom % 2);
            cfg_a = int'($urandom % 4);
            cfg_b = int'($urandom % 4);
            cfg_lock = 0;
            cfg_mid = bit'($urandom % 2);
            cfg_ncyc = 2 * (cfg_center ? 2 * cfg_top : cfg_top + 1) * (cfg_a + 1) * (cfg_b + 1) + 5;
            run_case();
            if (n % 7 == 3) halt_test();
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule